// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation tree held in memory. A request carries the virtual address, an access kind (read or write) and the privilege of the requester (user or supervisor). The walker accepts it together with the current value of the table root input, which is the one piece of per-process state and is changed by software when the running process changes.

The walker reads the first-level (directory) entry through a request/response memory port. If that entry maps a 4 MB page, the walk ends there. If not, it reads one second-level entry. Each entry it reads is checked for presence, write permission and user permission. The result is either a physical address or a fault that reports its cause and the level at which it was found.

Each entry is one 32-bit word. The fields are:

| Bits | Meaning |
|---|---|
| 0 | present |
| 1 | writable |
| 2 | user-accessible |
| 7 | large page (directory entries only) |
| 31:12 | frame number |

The walker ignores all other bits. The virtual address is split into three fields:

| Bits | Meaning |
|---|---|
| 31:22 | directory index |
| 21:12 | second-level index |
| 11:0 | page offset |

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. While a walk is in progress, `req_ready` stays low and no new request is taken.
- R2: The first memory read of a walk targets the directory entry at address root + 4 × vaddr[31:22]. The second read, when there is one, targets {directory frame, 12'b0} + 4 × vaddr[21:12].
- R3: Once `mem_req_valid` is raised, it stays high and `mem_req_addr` stays unchanged until a cycle in which `mem_req_ready` is high.
- R4: If an entry has bit 0 (present) clear, the walk ends with cause 1 (not present). This check comes before any other check on that entry. A missing directory entry reports level 1 and causes no second read. A missing second-level entry reports level 2.
- R5: A write to a present entry with bit 1 (writable) clear ends the walk with cause 2 (write protect) at that entry's level. When both permissions are missing, cause 2 is reported rather than cause 3.
- R6: A user access to a present entry with bit 2 (user) clear ends the walk with cause 3 (user protect) at that entry's level. A supervisor access never faults on the user bit.
- R7: A present, permitted directory entry with bit 7 set ends the walk after one read. The physical address is then {entry[31:22], vaddr[21:0]}. Entry bits 21:12 do not affect the result.
- R8: A successful two-read walk returns {second-level entry[31:12], vaddr[11:0]}.
- R9: `done_valid` and `fault_valid` are each single-cycle pulses and are never high together. The walker is idle again in the cycle after a pulse. `fault_cause` and `fault_level` are zero whenever `fault_valid` is low.
- R10: The walker accepts a memory response after any number of wait cycles. The table root is sampled when the request is taken, so later changes to the root do not affect a walk that is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| table_root | input | 32 | Base address of the directory table for the current process |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read from memory |
| done_valid | output | 1 | Translation succeeded (one-cycle pulse) |
| done_paddr | output | 32 | Physical address, valid with `done_valid` |
| fault_valid | output | 1 | Translation faulted (one-cycle pulse) |
| fault_cause | output | 2 | 1 not present, 2 write protect, 3 user protect |
| fault_level | output | 2 | 1 directory entry, 2 second-level entry |

## Verification
The walker is driven with addresses whose directory entries cover the main cases:
- a normal table pointer, which separates the two-read path from the one-read path;
- a large-page mapping whose unused frame bits are nonzero, which shows whether the large-page address takes the wrong bits;
- a missing directory entry, which shows whether a not-present directory stops the walk or wrongly goes on to a second read.

Second-level entries that are read-only, supervisor-only or missing are tested with both access kinds and both privileges. These combinations show whether a fault is taken at the wrong level or with the wrong cause. One entry lacks both the writable and the user bit, and it fixes the order of the permission checks. The first and last table indices check the entry address arithmetic. A second table root, changed in the middle of a walk, shows whether the root was sampled at the right time. Response latencies of zero to seven cycles and a toggling request-ready signal check the memory handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;
    localparam int ENT_LG  = 2;
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int L2_LSB  = OFF_W;
    localparam int L1_LSB  = OFF_W + IDX_W;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_LARGE   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_WAIT_DIR,
        ST_READ_PTE,
        ST_WAIT_PTE,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_WRITE  = 2'd2,
        CAUSE_USER   = 2'd3
    } fault_cause_e;

    typedef struct packed {
        walk_state_e          state;
        logic [ADDR_W-1:0]    vaddr;
        logic                 is_write;
        logic                 is_user;
        logic [ADDR_W-1:0]    root;
        logic [FRAME_W-1:0]   dir_frame;
        logic [ADDR_W-1:0]    paddr;
        fault_cause_e         cause;
        logic [1:0]           level;
    } walk_regs_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - ENT_LG;

    assign entry_addr = table_base + {{PAD_W{1'b0}}, index, {ENT_LG{1'b0}}};
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic         present,
    input  logic         writable,
    input  logic         user_ok,
    input  logic         is_write,
    input  logic         is_user,
    output fault_cause_e cause
);
    always_comb begin
        if (!present) begin
            cause = CAUSE_ABSENT;
        end else if (is_write && !writable) begin
            cause = CAUSE_WRITE;
        end else if (is_user && !user_ok) begin
            cause = CAUSE_USER;
        end else begin
            cause = CAUSE_NONE;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [31:0]       table_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              done_valid,
    output logic [31:0]       done_paddr,
    output logic              fault_valid,
    output logic [1:0]        fault_cause,
    output logic [1:0]        fault_level
);
    walk_regs_t q, d;

    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] pte_addr;
    fault_cause_e      rsp_cause;
    logic              unused_entry_bits;

    assign unused_entry_bits = ^{mem_rsp_data[OFF_W-1:BIT_LARGE+1],
                                 mem_rsp_data[BIT_LARGE-1:BIT_USER+1]};

    ptw_entry_addr u_dir_addr (
        .table_base (q.root),
        .index      (q.vaddr[L1_LSB +: IDX_W]),
        .entry_addr (dir_addr)
    );

    ptw_entry_addr u_pte_addr (
        .table_base ({q.dir_frame, {OFF_W{1'b0}}}),
        .index      (q.vaddr[L2_LSB +: IDX_W]),
        .entry_addr (pte_addr)
    );

    ptw_entry_check u_check (
        .present  (mem_rsp_data[BIT_PRESENT]),
        .writable (mem_rsp_data[BIT_WRITE]),
        .user_ok  (mem_rsp_data[BIT_USER]),
        .is_write (q.is_write),
        .is_user  (q.is_user),
        .cause    (rsp_cause)
    );

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state    = ST_READ_DIR;
                    d.vaddr    = req_vaddr;
                    d.is_write = req_write;
                    d.is_user  = req_user;
                    d.root     = table_root;
                    d.cause    = CAUSE_NONE;
                    d.level    = 2'd0;
                end
            end
            ST_READ_DIR: begin
                if (mem_req_ready) begin
                    d.state = ST_WAIT_DIR;
                end
            end
            ST_WAIT_DIR: begin
                if (mem_rsp_valid) begin
                    d.dir_frame = mem_rsp_data[ADDR_W-1:OFF_W];
                    if (rsp_cause != CAUSE_NONE) begin
                        d.state = ST_FAULT;
                        d.cause = rsp_cause;
                        d.level = 2'd1;
                    end else if (mem_rsp_data[BIT_LARGE]) begin
                        d.state = ST_DONE;
                        d.paddr = {mem_rsp_data[ADDR_W-1:L1_LSB], q.vaddr[L1_LSB-1:0]};
                    end else begin
                        d.state = ST_READ_PTE;
                    end
                end
            end
            ST_READ_PTE: begin
                if (mem_req_ready) begin
                    d.state = ST_WAIT_PTE;
                end
            end
            ST_WAIT_PTE: begin
                if (mem_rsp_valid) begin
                    if (rsp_cause != CAUSE_NONE) begin
                        d.state = ST_FAULT;
                        d.cause = rsp_cause;
                        d.level = 2'd2;
                    end else begin
                        d.state = ST_DONE;
                        d.paddr = {mem_rsp_data[ADDR_W-1:OFF_W], q.vaddr[OFF_W-1:0]};
                    end
                end
            end
            ST_DONE:  d.state = ST_IDLE;
            ST_FAULT: d.state = ST_IDLE;
            default:  d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.state == ST_IDLE);
    assign mem_req_valid = (q.state == ST_READ_DIR) || (q.state == ST_READ_PTE);
    assign mem_req_addr  = (q.state == ST_READ_PTE) ? pte_addr : dir_addr;
    assign done_valid    = (q.state == ST_DONE);
    assign done_paddr    = q.paddr;
    assign fault_valid   = (q.state == ST_FAULT);
    assign fault_cause   = (q.state == ST_FAULT) ? q.cause : CAUSE_NONE;
    assign fault_level   = (q.state == ST_FAULT) ? q.level : 2'd0;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [11:0] req_off,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        done_valid,
    input logic [11:0] done_off,
    input logic        fault_valid,
    input logic [1:0]  fault_cause,
    input logic [1:0]  fault_level
);
    logic [11:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (req_valid && req_ready) begin
            off_q <= req_off;
        end
    end

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    a_r9_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (!fault_valid && req_ready));

    a_r9_quiet_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_valid |-> (fault_cause == 2'd0 && fault_level == 2'd0));

    a_r4_cause_level: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_cause != 2'd0 && (fault_level == 2'd1 || fault_level == 2'd2)));

    a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_off == off_q));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (req_vaddr[11:0]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_off      (done_paddr[11:0]),
    .fault_valid   (fault_valid),
    .fault_cause   (fault_cause),
    .fault_level   (fault_level)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] table_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic        fault_valid;
    logic [1:0]  fault_cause;
    logic [1:0]  fault_level;

    int checks = 0;
    int fails = 0;
    int r3_checks = 0;
    int r3_fails = 0;

    always #10 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .table_root(table_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_paddr(done_paddr),
        .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_level(fault_level)
    );

    // Memory model: sparse word store, configurable latency and request stalls.
    logic [31:0] mem_words [logic [31:0]];
    int          lat = 0;
    logic        stall = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          cnt = 0;
    int          hs_cnt = 0;
    logic [31:0] addr_hist [64];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_words.exists(a) ? mem_words[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(pend_addr);
                pend          <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            cnt       <= lat;
            addr_hist[hs_cnt[5:0]] <= mem_req_addr;
            hs_cnt    <= hs_cnt + 1;
        end
    end

    // R3 monitor: a stalled request must hold valid and address.
    logic        prev_stalled = 1'b0;
    logic [31:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n && prev_stalled) begin
            r3_checks++;
            if (!(mem_req_valid && mem_req_addr == prev_addr)) begin
                r3_fails++;
                $display("FAIL R3 request dropped: valid=%0b addr=%h expected valid=1 addr=%h",
                         mem_req_valid, mem_req_addr, prev_addr);
            end
        end
        prev_stalled = mem_req_valid && !mem_req_ready;
        prev_addr    = mem_req_addr;
    end

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [31:0] root;
        logic        flt;
        logic [1:0]  cause;
        logic [1:0]  lvl;
        logic [31:0] pa;
        logic [1:0]  reads;
        logic [3:0]  lt;
        logic        stl;
    } vec_t;

    localparam int NV = 16;
    localparam logic [31:0] RA = 32'h0001_0000;
    localparam logic [31:0] RB = 32'h0003_0000;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_3ABC, 1'b0, 1'b1, RA, 1'b0, 2'd0, 2'd0, 32'hABCD_0ABC, 2'd2, 4'd0, 1'b0}, // R8
        '{32'h0040_3123, 1'b1, 1'b1, RA, 1'b0, 2'd0, 2'd0, 32'hABCD_0123, 2'd2, 4'd3, 1'b1}, // R8 R10 R3
        '{32'h0040_4010, 1'b0, 1'b1, RA, 1'b0, 2'd0, 2'd0, 32'h1234_5010, 2'd2, 4'd1, 1'b0}, // R5 read ok
        '{32'h0040_4010, 1'b1, 1'b1, RA, 1'b1, 2'd2, 2'd2, 32'h0,        2'd2, 4'd0, 1'b0}, // R5 level 2
        '{32'h0040_5FFF, 1'b1, 1'b0, RA, 1'b0, 2'd0, 2'd0, 32'h5555_5FFF, 2'd2, 4'd7, 1'b0}, // R6 supervisor
        '{32'h0040_5000, 1'b0, 1'b1, RA, 1'b1, 2'd3, 2'd2, 32'h0,        2'd2, 4'd0, 1'b1}, // R6 level 2
        '{32'h0040_6000, 1'b0, 1'b0, RA, 1'b1, 2'd1, 2'd2, 32'h0,        2'd2, 4'd2, 1'b0}, // R4 level 2
        '{32'h00C0_0000, 1'b0, 1'b0, RA, 1'b1, 2'd1, 2'd1, 32'h0,        2'd1, 4'd0, 1'b0}, // R4 level 1
        '{32'h0080_0000, 1'b1, 1'b1, RA, 1'b1, 2'd2, 2'd1, 32'h0,        2'd1, 4'd0, 1'b0}, // R5 level 1
        '{32'h0080_0000, 1'b0, 1'b1, RA, 1'b0, 2'd0, 2'd0, 32'h6666_6000, 2'd2, 4'd0, 1'b0}, // R2 index 0
        '{32'h0123_4567, 1'b0, 1'b1, RA, 1'b0, 2'd0, 2'd0, 32'h0C23_4567, 2'd1, 4'd5, 1'b1}, // R7
        '{32'h0140_0008, 1'b0, 1'b1, RA, 1'b1, 2'd3, 2'd1, 32'h0,        2'd1, 4'd0, 1'b0}, // R6 large
        '{32'h0140_0008, 1'b1, 1'b0, RA, 1'b0, 2'd0, 2'd0, 32'h4000_0008, 2'd1, 4'd0, 1'b0}, // R7 supervisor
        '{32'hFFFF_FFFC, 1'b0, 1'b1, RA, 1'b0, 2'd0, 2'd0, 32'h9999_9FFC, 2'd2, 4'd1, 1'b0}, // R2 last index
        '{32'h01C0_0000, 1'b1, 1'b1, RA, 1'b1, 2'd2, 2'd1, 32'h0,        2'd1, 4'd0, 1'b0}, // R5 priority
        '{32'h0040_3ABC, 1'b0, 1'b1, RB, 1'b0, 2'd0, 2'd0, 32'h3333_3ABC, 2'd2, 4'd4, 1'b0}  // R10 root B
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int base;
        int reads;
        int waited;
        logic [31:0] exp_dir;
        lat   = int'(v.lt);
        stall = v.stl;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base       = hs_cnt;
        req_valid  = 1'b1;
        req_vaddr  = v.va;
        req_write  = v.wr;
        req_user   = v.usr;
        table_root = v.root;
        @(negedge clk);
        req_valid  = 1'b0;
        table_root = 32'hDEAD_0000; // R10: changes after acceptance must not matter
        check(!req_ready, "R1 ready low while walking", {31'b0, req_ready}, 32'h0);
        waited = 0;
        while (!done_valid && !fault_valid && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        reads = hs_cnt - base;
        if (v.flt) begin
            check(fault_valid && !done_valid && fault_cause == v.cause && fault_level == v.lvl,
                  "R4/R5/R6 fault cause and level",
                  {fault_valid, done_valid, 26'b0, fault_cause, fault_level},
                  {2'b10, 26'b0, v.cause, v.lvl});
        end else begin
            check(done_valid && !fault_valid && done_paddr == v.pa,
                  "R7/R8/R10 physical address", done_paddr, v.pa);
        end
        check(reads == int'(v.reads), "R4/R7 read count", reads, {30'b0, v.reads});
        exp_dir = v.root + {20'b0, v.va[31:22], 2'b00};
        check(addr_hist[base[5:0]] == exp_dir, "R2 directory entry address",
              addr_hist[base[5:0]], exp_dir);
        @(negedge clk);
        check(!done_valid && !fault_valid && req_ready, "R9 single pulse then idle",
              {29'b0, done_valid, fault_valid, req_ready}, 32'h1);
        table_root = RA;
    endtask

    initial begin
        // Directory of root A
        mem_words[32'h0001_0004] = 32'h0002_0007;
        mem_words[32'h0001_0008] = 32'h0002_1005;
        mem_words[32'h0001_0010] = 32'h0C3F_F087;
        mem_words[32'h0001_0014] = 32'h4000_0083;
        mem_words[32'h0001_0018] = 32'h0002_3003;
        mem_words[32'h0001_001C] = 32'h0002_4001;
        mem_words[32'h0001_0FFC] = 32'h0002_2007;
        // Second-level tables
        mem_words[32'h0002_000C] = 32'hABCD_0007;
        mem_words[32'h0002_0010] = 32'h1234_5005;
        mem_words[32'h0002_0014] = 32'h5555_5003;
        mem_words[32'h0002_1000] = 32'h6666_6007;
        mem_words[32'h0002_2FFC] = 32'h9999_9007;
        mem_words[32'h0002_3000] = 32'h1111_1007;
        // Directory and table of root B
        mem_words[32'h0003_0004] = 32'h0002_5007;
        mem_words[32'h0002_500C] = 32'h3333_3007;

        repeat (3) @(negedge clk);
        check(req_ready && !mem_req_valid && !done_valid && !fault_valid &&
              fault_cause == 2'd0 && fault_level == 2'd0, "R9 reset state",
              {26'b0, req_ready, mem_req_valid, done_valid, fault_valid, fault_cause},
              32'h20);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1 idle after reset", {31'b0, req_ready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R6: user-protect at the directory level with a permitted write
        run_vec('{32'h0180_0000, 1'b1, 1'b1, RA, 1'b1, 2'd3, 2'd1, 32'h0, 2'd1, 4'd0, 1'b0});
        // R1: a request held high during a walk is taken only once idle again
        stall = 1'b0;
        lat   = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0040_3001; req_write = 1'b0; req_user = 1'b0;
        table_root = RA;
        @(negedge clk);
        begin
            int walks;
            walks = 0;
            for (int c = 0; c < 40; c++) begin
                if (done_valid) walks++;
                @(negedge clk);
            end
            req_valid = 1'b0;
            check(walks >= 2 && walks <= 10, "R1 back-to-back walks complete", walks, 32'd2);
        end
        repeat (10) @(negedge clk);

        checks += r3_checks;
        fails  += r3_fails;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule